// File: doc/BRIEF.md
# ADC Result Bank with Completion Flags

This block is the storage end of an ADC subsystem. The sequence controller hands it a raw 8-bit or 10-bit conversion result and the index of one of eight result slots. The block formats the raw code into a 16-bit word, stores it in that slot and raises the slot's completion flag. Software reads the eight flags as one status word and reads each slot's 16-bit word through a slot selector.

Formatting follows the configuration present on the write cycle. In left-aligned form the code's MSB lands on bit 15, and the signed option gives two's complement by inverting the top bit. In right-aligned form the code's LSB lands on bit 0 and the value is always unsigned.

A flag clears in one of two ways. In ordered mode, software must read the status word while the flag is set and then read the result. In fast mode, any access to the result clears its flag. Writing a slot whose flag is still set raises a sticky overrun flag. Starting a new sequence clears every flag.

Each slot's flag is a three-state machine with these states:
- `SL_EMPTY`: the flag is clear.
- `SL_READY`: the flag is set, but the slot has not been armed for an ordered clear.
- `SL_ARMED`: the flag is set and a status read has armed the slot.

The named transitions are:
- `T_FILL`: a write moves any state to `SL_READY`.
- `T_FLUSH`: a sequence start moves any state to `SL_EMPTY`.
- `T_ARM`: a status read moves `SL_READY` to `SL_ARMED`.
- `T_FAST`: a fast-mode result access moves `SL_READY` or `SL_ARMED` to `SL_EMPTY`.
- `T_TAKE`: a result access in ordered mode moves `SL_ARMED` to `SL_EMPTY`.

`T_FILL` has priority over `T_FLUSH`, and `T_FLUSH` has priority over the read transitions.

Top module: `adcrb_bank`

## Requirements
- R1: After reset, all completion flags read 0, the overrun flag reads 0 and every slot reads 16'h0000. A slot's word changes only when that slot is written.
- R2: A write with `wr_valid`=1 stores the formatted word in slot `wr_slot` and sets `done_flags[wr_slot]`. Both are visible on the cycle after the write edge, and `res_data` shows the word of slot `res_slot` without extra delay.
- R3: In left-aligned unsigned form (`cfg_left`=1, `cfg_signed`=0), a 10-bit code (`cfg_ten_bit`=1) appears as {raw[9:0], 6'b0}. An 8-bit code (`cfg_ten_bit`=0) appears as {raw[7:0], 8'b0}, and raw[9:8] are ignored.
- R4: In left-aligned signed form (`cfg_left`=1, `cfg_signed`=1), the R3 word has bit 15 inverted, so mid-scale (10'h200 or 8'h80) reads 16'h0000.
- R5: In right-aligned form (`cfg_left`=0), the code is zero-extended into bit 0 upward, whatever the value of `cfg_signed`.
- R6: In ordered mode (`cfg_fast_clr`=0), a result access to slot x clears its flag only if a status read (`stat_rd`) saw the flag set after the last write to x. A write to x cancels any earlier arming. A result access without arming leaves the flag set.
- R7: In fast mode (`cfg_fast_clr`=1), a result access (`res_rd` with `res_slot`=x) clears flag x with no status read. Other flags are unaffected.
- R8: A write into a slot whose flag is set raises `ovr_flag`, and the new word replaces the old one. `ovr_flag` stays set until `ovr_wr1` or `seq_start`. A raise and a clear in the same cycle leave it set.
- R9: `seq_start` clears all flags and `ovr_flag` without touching stored words. A write in the same cycle still stores its word and sets its flag, and raises no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Result write from the sequence controller |
| wr_slot | input | 3 | Target slot of the write |
| wr_raw | input | 10 | Raw conversion code (8-bit codes in bits 7:0) |
| cfg_ten_bit | input | 1 | 1 = 10-bit code, 0 = 8-bit code |
| cfg_left | input | 1 | 1 = left-aligned, 0 = right-aligned |
| cfg_signed | input | 1 | 1 = two's complement (left-aligned only) |
| cfg_fast_clr | input | 1 | 1 = any result access clears its flag |
| seq_start | input | 1 | New-sequence mode write: clears all flags |
| stat_rd | input | 1 | Software read of the flag word |
| res_rd | input | 1 | Software access to the result of `res_slot` |
| res_slot | input | 3 | Slot shown on `res_data` |
| ovr_wr1 | input | 1 | Software writes 1 to the overrun flag |
| res_data | output | 16 | Formatted word of slot `res_slot` |
| done_flags | output | 8 | Per-slot completion flags |
| ovr_flag | output | 1 | Sticky result-overrun flag |

## Verification
The hardest case to reach is a slot that has been armed by a status read and is then overwritten before its result is read. The flag looks the same from outside, but it must no longer clear on the next result access. The stimulus reaches this case with three steps in ordered mode: a write, a status read, and a second write to the same slot. A result access follows, and the flag must stay set while the overrun flag and the new word become visible. Same-cycle collisions are also driven directly: a sequence start together with a write, and an overrun raise together with a software clear.

// File: rtl/adcrb_pkg.sv
package adcrb_pkg;
    typedef enum logic [1:0] {
        SL_EMPTY = 2'd0,
        SL_READY = 2'd1,
        SL_ARMED = 2'd2
    } slot_state_t;
endpackage

// File: rtl/adcrb_fmt.sv
module adcrb_fmt #(
    parameter int RES_HI = 10,
    parameter int RES_LO = 8,
    parameter int REG_W  = 16
) (
    input  logic [RES_HI-1:0] raw,
    input  logic              ten_bit,
    input  logic              left,
    input  logic              sgn,
    output logic [REG_W-1:0]  word
);
    localparam int PAD_HI = REG_W - RES_HI;
    localparam int PAD_LO = REG_W - RES_LO;

    logic [REG_W-1:0] left_w;
    logic [REG_W-1:0] right_w;

    always_comb begin
        if (ten_bit) begin
            left_w  = {raw, {PAD_HI{1'b0}}};
            right_w = {{PAD_HI{1'b0}}, raw};
        end else begin
            left_w  = {raw[RES_LO-1:0], {PAD_LO{1'b0}}};
            right_w = {{PAD_LO{1'b0}}, raw[RES_LO-1:0]};
        end
        if (left) begin
            word = left_w;
            if (sgn) begin
                word[REG_W-1] = ~left_w[REG_W-1];
            end
        end else begin
            word = right_w;
        end
    end
endmodule

// File: rtl/adcrb_slot.sv
module adcrb_slot
    import adcrb_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wr_word,
    input  logic             seq_clr,
    input  logic             stat_rd,
    input  logic             res_hit,
    input  logic             fast_clr,
    output logic [REG_W-1:0] data_q,
    output logic             flag,
    output logic             ovr_evt
);
    slot_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SL_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_hit) begin
            data_q <= wr_word;
        end
    end

    always_comb begin
        state_d = state_q;
        if (wr_hit) begin
            state_d = SL_READY;                 // T_FILL
        end else if (seq_clr) begin
            state_d = SL_EMPTY;                 // T_FLUSH
        end else begin
            unique case (state_q)
                SL_EMPTY: state_d = SL_EMPTY;
                SL_READY: begin
                    if (res_hit && fast_clr) state_d = SL_EMPTY;   // T_FAST
                    else if (stat_rd)        state_d = SL_ARMED;   // T_ARM
                end
                SL_ARMED: begin
                    if (res_hit) state_d = SL_EMPTY;   // T_TAKE / T_FAST
                end
                default: state_d = SL_EMPTY;
            endcase
        end
    end

    always_comb begin
        flag    = (state_q != SL_EMPTY);
        ovr_evt = wr_hit && !seq_clr && (state_q != SL_EMPTY);
    end

    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> flag);

    assert_data_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(data_q));

    assert_ordered_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SL_READY && res_hit && !fast_clr && !wr_hit && !seq_clr) |=> flag);

    assert_armed_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SL_ARMED && res_hit && !wr_hit && !seq_clr) |=> !flag);

    assert_fast_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hit && fast_clr && !wr_hit && !seq_clr) |=> !flag);

    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_clr && !wr_hit) |=> !flag);
endmodule

// File: rtl/adcrb_bank.sv
module adcrb_bank
    import adcrb_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int RES_HI    = 10,
    parameter int RES_LO    = 8,
    parameter int REG_W     = 16,
    localparam int SW       = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [SW-1:0]        wr_slot,
    input  logic [RES_HI-1:0]    wr_raw,
    input  logic                 cfg_ten_bit,
    input  logic                 cfg_left,
    input  logic                 cfg_signed,
    input  logic                 cfg_fast_clr,
    input  logic                 seq_start,
    input  logic                 stat_rd,
    input  logic                 res_rd,
    input  logic [SW-1:0]        res_slot,
    input  logic                 ovr_wr1,
    output logic [REG_W-1:0]     res_data,
    output logic [NUM_SLOTS-1:0] done_flags,
    output logic                 ovr_flag
);
    logic [REG_W-1:0]     fmt_word;
    logic [REG_W-1:0]     slot_data [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] ovr_evt;

    adcrb_fmt #(
        .RES_HI (RES_HI),
        .RES_LO (RES_LO),
        .REG_W  (REG_W)
    ) u_fmt (
        .raw     (wr_raw),
        .ten_bit (cfg_ten_bit),
        .left    (cfg_left),
        .sgn     (cfg_signed),
        .word    (fmt_word)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        adcrb_slot #(
            .REG_W (REG_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (wr_valid && (wr_slot == SW'(i))),
            .wr_word  (fmt_word),
            .seq_clr  (seq_start),
            .stat_rd  (stat_rd),
            .res_hit  (res_rd && (res_slot == SW'(i))),
            .fast_clr (cfg_fast_clr),
            .data_q   (slot_data[i]),
            .flag     (done_flags[i]),
            .ovr_evt  (ovr_evt[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_flag <= 1'b0;
        end else if (|ovr_evt) begin
            ovr_flag <= 1'b1;
        end else if (seq_start || ovr_wr1) begin
            ovr_flag <= 1'b0;
        end
    end

    assign res_data = slot_data[res_slot];

    assert_overrun_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !seq_start && done_flags[wr_slot]) |=> ovr_flag);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_wr1 && !seq_start) |=> ovr_flag);

    assert_seq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start && !wr_valid) |=> (done_flags == '0 && !ovr_flag));

    assert_single_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start && wr_valid) |=> ($countones(done_flags) == 1 && !ovr_flag));
endmodule

// File: tb/adcrb_bank_bench.sv
`timescale 1ns/1ps
module adcrb_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [2:0]  wr_slot = '0;
    logic [9:0]  wr_raw = '0;
    logic        cfg_ten_bit = 1'b1;
    logic        cfg_left = 1'b1;
    logic        cfg_signed = 1'b0;
    logic        cfg_fast_clr = 1'b0;
    logic        seq_start = 1'b0;
    logic        stat_rd = 1'b0;
    logic        res_rd = 1'b0;
    logic [2:0]  res_slot = '0;
    logic        ovr_wr1 = 1'b0;
    logic [15:0] res_data;
    logic [7:0]  done_flags;
    logic        ovr_flag;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adcrb_bank u_adcrb_bank (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_slot(wr_slot),
        .wr_raw(wr_raw), .cfg_ten_bit(cfg_ten_bit), .cfg_left(cfg_left),
        .cfg_signed(cfg_signed), .cfg_fast_clr(cfg_fast_clr),
        .seq_start(seq_start), .stat_rd(stat_rd), .res_rd(res_rd),
        .res_slot(res_slot), .ovr_wr1(ovr_wr1), .res_data(res_data),
        .done_flags(done_flags), .ovr_flag(ovr_flag)
    );

    // {ten_bit, left, signed, 3'b0, raw[9:0], expected[15:0]}
    localparam logic [31:0] VEC [12] = '{
        {1'b1, 1'b1, 1'b0, 3'b0, 10'h3FF, 16'hFFC0},
        {1'b1, 1'b1, 1'b1, 3'b0, 10'h3FF, 16'h7FC0},
        {1'b1, 1'b1, 1'b1, 3'b0, 10'h200, 16'h0000},
        {1'b1, 1'b0, 1'b0, 3'b0, 10'h2A5, 16'h02A5},
        {1'b1, 1'b0, 1'b1, 3'b0, 10'h2A5, 16'h02A5},
        {1'b0, 1'b1, 1'b0, 3'b0, 10'h3A5, 16'hA500},
        {1'b0, 1'b1, 1'b1, 3'b0, 10'h0A5, 16'h2500},
        {1'b0, 1'b0, 1'b0, 3'b0, 10'h1FF, 16'h00FF},
        {1'b0, 1'b0, 1'b1, 3'b0, 10'h080, 16'h0080},
        {1'b1, 1'b1, 1'b0, 3'b0, 10'h001, 16'h0040},
        {1'b0, 1'b1, 1'b1, 3'b0, 10'h000, 16'h8000},
        {1'b1, 1'b1, 1'b1, 3'b0, 10'h000, 16'h8000}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        wr_valid = 1'b0; stat_rd = 1'b0; res_rd = 1'b0;
        seq_start = 1'b0; ovr_wr1 = 1'b0;
    endtask

    task automatic put(input logic [2:0] s, input logic [9:0] raw);
        wr_valid = 1'b1; wr_slot = s; wr_raw = raw;
    endtask

    task automatic take(input logic [2:0] s);
        res_rd = 1'b1; res_slot = s;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset flags", {8'h0, done_flags}, 16'h0);
        check("R1 reset ovr", {15'h0, ovr_flag}, 16'h0);
        res_slot = 3'd5; #1;
        check("R1 reset data", res_data, 16'h0000);
        rst_n = 1'b1;
        tick();

        // Formatting table, fast clear between vectors
        cfg_fast_clr = 1'b1;
        for (int i = 0; i < 12; i++) begin
            logic [2:0] s;
            string tg;
            s = 3'(i % 8);
            cfg_ten_bit = VEC[i][31];
            cfg_left    = VEC[i][30];
            cfg_signed  = VEC[i][29];
            put(s, VEC[i][25:16]);
            tick();
            tg = !VEC[i][30] ? "R5" : (VEC[i][29] ? "R4" : "R3");
            res_slot = s; #1;
            check($sformatf("%s vector %0d", tg, i), res_data, VEC[i][15:0]);
            check("R2 flag set", {15'h0, done_flags[s]}, 16'h1);
            take(s);
            tick();
            check("R7 fast clear", {15'h0, done_flags[s]}, 16'h0);
        end
        check("R8 no overrun in table", {15'h0, ovr_flag}, 16'h0);

        cfg_ten_bit = 1'b1; cfg_left = 1'b0; cfg_signed = 1'b0;

        // R7: fast clear touches only the accessed slot
        put(3'd1, 10'h011); tick();
        put(3'd2, 10'h022); tick();
        take(3'd1); tick();
        check("R7 only slot1 cleared", {8'h0, done_flags}, 16'h0004);
        take(3'd2); tick();

        // R6: ordered clearing
        cfg_fast_clr = 1'b0;
        put(3'd3, 10'h033); tick();
        take(3'd3); tick();
        check("R6 access without status read", {15'h0, done_flags[3]}, 16'h1);
        stat_rd = 1'b1; tick();
        take(3'd3); tick();
        check("R6 status then result clears", {15'h0, done_flags[3]}, 16'h0);

        // R6 / R8: rewrite of an armed slot
        put(3'd4, 10'h044); tick();
        stat_rd = 1'b1; tick();
        put(3'd4, 10'h155); tick();
        check("R8 overrun raised", {15'h0, ovr_flag}, 16'h1);
        res_slot = 3'd4; #1;
        check("R8 new data replaces old", res_data, 16'h0155);
        take(3'd4); tick();
        check("R6 rewrite cancels arming", {15'h0, done_flags[4]}, 16'h1);
        check("R8 overrun sticky", {15'h0, ovr_flag}, 16'h1);
        stat_rd = 1'b1; tick();
        take(3'd4); tick();
        check("R6 re-armed clear", {15'h0, done_flags[4]}, 16'h0);
        ovr_wr1 = 1'b1; tick();
        check("R8 write-1 clears", {15'h0, ovr_flag}, 16'h0);

        // R8: raise wins over clear in the same cycle
        put(3'd5, 10'h005); tick();
        put(3'd5, 10'h006); ovr_wr1 = 1'b1; tick();
        check("R8 raise beats clear", {15'h0, ovr_flag}, 16'h1);

        // R9: sequence start
        put(3'd6, 10'h066); tick();
        seq_start = 1'b1; tick();
        check("R9 flags cleared", {8'h0, done_flags}, 16'h0);
        check("R9 ovr cleared", {15'h0, ovr_flag}, 16'h0);
        res_slot = 3'd6; #1;
        check("R9 data kept", res_data, 16'h0066);
        put(3'd0, 10'h001); tick();
        put(3'd7, 10'h077); tick();
        put(3'd7, 10'h078); seq_start = 1'b1; tick();
        check("R9 write with start", {8'h0, done_flags}, 16'h0080);
        check("R9 no overrun with start", {15'h0, ovr_flag}, 16'h0);
        res_slot = 3'd7; #1;
        check("R9 stored word", res_data, 16'h0078);

        // R1: untouched slot keeps its word
        res_slot = 3'd2; #1;
        check("R1 slot2 retained", res_data, 16'h0022);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule